// File: doc/BRIEF.md
# Fractional Output Clock Generator

This block makes a square wave for one output pin from the 20 MHz system clock. A 16-bit phase accumulator adds an unsigned frequency word each time a prescaler sends an enable pulse. The prescaler runs at the system rate divided by a power of two, from 1 to 128, picked by a 3-bit select. The output pin follows the accumulator's top bit. The output frequency is therefore freq / 65536 times the chosen reference rate, which is 20 MHz / 2^sel.

A write port loads the frequency word and the rate select together and starts the generator. A separate stop pulse turns it off and clears its phase. The stored settings and the run state can always be read back. A pin-mode input passes the wave to the pin only while that pin is set to clock-drive mode. The write sequencer that drives the register port, the pin multiplexing and the pad are outside this block.

Top module: `fcg_top`

## Requirements
- R1: After reset the output is 0, the readback frequency word and rate select are 0, and the run flag reads 0.
- R2: A write pulse stores the frequency word and rate select and sets the run flag. All three read back from the cycle after the write edge.
- R3: Count the clock edges after the edge that turned the generator on as j = 1, 2, 3, and so on. The accumulator advances at edge j exactly when j is a multiple of 2^sel, using the sel held before that edge, for each sel from 0 to 7.
- R4: Each advance adds the frequency word to the accumulator modulo 2^16. The output equals accumulator bit 15.
- R5: A frequency word of 0 holds the accumulator, and so the output, at a constant value.
- R6: A write made while the generator runs changes the settings for the following edges. It does not clear the accumulator phase or the edge count j.
- R7: A stop pulse clears the accumulator and the output to 0 and clears the run flag, all at the same edge. A stop and a write in the same cycle behave as a stop alone.
- R8: While the pin-mode input is low the output is 0. The accumulator keeps running, so the wave returns in phase when the pin-mode input goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write pulse: load settings and run |
| wr_freq | input | 16 | Frequency word to load |
| wr_sel | input | 3 | Rate select to load (divide by 2^sel) |
| off_req | input | 1 | Stop pulse |
| pin_clk_mode | input | 1 | Pin is configured for clock drive |
| rd_freq | output | 16 | Stored frequency word |
| rd_sel | output | 3 | Stored rate select |
| rd_on | output | 1 | Run flag |
| clk_out | output | 1 | Square wave to the pin |

## Verification
The bench sweeps every rate select against a set of frequency words: 0, 1, half scale, full scale and several odd values. It predicts the output from the edge count and the wrap of the sum, every cycle. A prescaler whose first pulse lands one edge early or late would shift the whole waveform. A sum without the 16-bit wrap would go wrong for the full-scale word. A mid-run write that resets the phase would break the continuity check of R6. A stop that clears one cycle late would leave a stray high output. A simultaneous stop and write that lets the write win would leave the run flag set. An output gate that also froze the accumulator would come back out of phase after the pin-mode input rises.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    // Width of the phase accumulator and the frequency word.
    localparam int unsigned ACC_W = 16;
    // Width of the reference-rate select.
    localparam int unsigned SEL_W = 3;
    // The prescale counter needs one bit per possible power-of-two step.
    localparam int unsigned PRE_W = (1 << SEL_W) - 1;

    typedef logic [ACC_W-1:0] word_t;
    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [PRE_W-1:0] pre_t;

    // Settings held by the register stage.
    typedef struct packed {
        logic  run;
        sel_t  sel;
        word_t freq;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{run: 1'b0, sel: '0, freq: '0};

    // Low-order mask with sel ones: the prescaler fires when the counter's
    // masked bits are all ones, which yields one pulse per 2^sel cycles.
    function automatic pre_t rate_mask(input sel_t sel);
        pre_t m;
        for (int i = 0; i < int'(PRE_W); i++) begin
            m[i] = (i < int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/fcg_cfg_reg.sv
module fcg_cfg_reg
    import fcg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_freq,
    input  sel_t  wr_sel,
    input  logic  off_req,
    output cfg_t  cfg
);

    cfg_t cfg_q;
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (off_req) begin
            // Stop dominates; settings are kept for readback.
            cfg_d.run = 1'b0;
        end else if (wr_en) begin
            cfg_d.run  = 1'b1;
            cfg_d.freq = wr_freq;
            cfg_d.sel  = wr_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/fcg_prescaler.sv
module fcg_prescaler
    import fcg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  sel_t sel,
    output logic tick
);

    pre_t cnt_q;
    pre_t mask;

    always_comb begin
        mask = rate_mask(sel);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + pre_t'(1);
        end
    end

    // Fires on the last cycle of each 2^sel window of the free count.
    assign tick = !clear && ((cnt_q & mask) == mask);

endmodule

// File: rtl/fcg_phase_acc.sv
module fcg_phase_acc
    import fcg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  tick,
    input  word_t step,
    output word_t acc
);

    word_t acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= acc_q + step;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/fcg_top.sv
module fcg_top
    import fcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ACC_W-1:0]  wr_freq,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              off_req,
    input  logic              pin_clk_mode,
    output logic [ACC_W-1:0]  rd_freq,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              rd_on,
    output logic              clk_out
);

    cfg_t  cfg;
    logic  clear;
    logic  tick;
    word_t acc_q;

    fcg_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_freq (wr_freq),
        .wr_sel  (wr_sel),
        .off_req (off_req),
        .cfg     (cfg)
    );

    // Clear while stopped and at the stopping edge itself.
    assign clear = off_req || !cfg.run;

    fcg_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .sel   (cfg.sel),
        .tick  (tick)
    );

    fcg_phase_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .tick  (tick),
        .step  (cfg.freq),
        .acc   (acc_q)
    );

    assign rd_freq = cfg.freq;
    assign rd_sel  = cfg.sel;
    assign rd_on   = cfg.run;
    assign clk_out = acc_q[ACC_W-1] && pin_clk_mode;

endmodule

// File: rtl/fcg_checker.sv
module fcg_checker
    import fcg_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_en,
    input word_t wr_freq,
    input sel_t  wr_sel,
    input logic  off_req,
    input logic  pin_clk_mode,
    input word_t rd_freq,
    input sel_t  rd_sel,
    input logic  rd_on,
    input logic  clk_out,
    input word_t acc,
    input logic  tick
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!clk_out && !rd_on && rd_freq == '0 && rd_sel == '0));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !off_req) |=> (rd_on && rd_freq == $past(wr_freq) && rd_sel == $past(wr_sel)));

    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (tick && rd_sel != '0 && !wr_en) |=> !tick);

    a_r4_step_adds: assert property (@(posedge clk) disable iff (rst)
        (tick && !off_req) |=> (acc == word_t'($past(acc) + $past(rd_freq))));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !off_req && rd_on) |=> $stable(acc));

    a_r5_zero_word: assert property (@(posedge clk) disable iff (rst)
        (rd_freq == '0 && !wr_en && !off_req) |=> $stable(acc));

    a_r7_stop_clears: assert property (@(posedge clk) disable iff (rst)
        off_req |=> (!rd_on && !clk_out && acc == '0));

    a_r8_pin_gate: assert property (@(posedge clk) disable iff (rst)
        !pin_clk_mode |-> !clk_out);

endmodule

bind fcg_top fcg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_freq      (wr_freq),
    .wr_sel       (wr_sel),
    .off_req      (off_req),
    .pin_clk_mode (pin_clk_mode),
    .rd_freq      (rd_freq),
    .rd_sel       (rd_sel),
    .rd_on        (rd_on),
    .clk_out      (clk_out),
    .acc          (acc_q),
    .tick         (tick)
);

// File: tb/sim_fcg_top.sv
module sim_fcg_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_freq = '0;
    logic [2:0]  wr_sel = '0;
    logic        off_req = 1'b0;
    logic        pin_clk_mode = 1'b1;
    logic [15:0] rd_freq;
    logic [2:0]  rd_sel;
    logic        rd_on;
    logic        clk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string out_tag = "R1";

    // Requirement-level reference state.
    bit          m_on = 1'b0;
    int unsigned m_acc = 0;
    int unsigned m_j = 0;
    int unsigned m_freq = 0;
    int unsigned m_sel = 0;

    fcg_top u0 (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_freq      (wr_freq),
        .wr_sel       (wr_sel),
        .off_req      (off_req),
        .pin_clk_mode (pin_clk_mode),
        .rd_freq      (rd_freq),
        .rd_sel       (rd_sel),
        .rd_on        (rd_on),
        .clk_out      (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge j after enabling advances when j is a multiple of 2^sel (R3),
    // adding the word modulo 2^16 (R4); stop clears at once (R7).
    always @(posedge clk) begin
        if (rst) begin
            m_on = 1'b0; m_acc = 0; m_j = 0; m_freq = 0; m_sel = 0;
        end else begin
            if (m_on) begin
                m_j = m_j + 1;
                if ((m_j % (1 << m_sel)) == 0) m_acc = (m_acc + m_freq) & 32'hFFFF;
            end
            if (off_req) begin
                m_on = 1'b0; m_acc = 0; m_j = 0;
            end else if (wr_en) begin
                m_freq = wr_freq; m_sel = wr_sel;
                if (!m_on) begin m_on = 1'b1; m_j = 0; end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step_check();
        int exp_out;
        @(negedge clk);
        exp_out = ((m_acc >> 15) & 1) & int'(pin_clk_mode);
        check(out_tag, int'(clk_out), exp_out);
        check("R2 readback freq", int'(rd_freq), int'(m_freq));
        check("R2 readback sel", int'(rd_sel), int'(m_sel));
        check("R7 run flag", int'(rd_on), int'(m_on));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step_check();
    endtask

    task automatic write_cfg(input logic [15:0] f, input logic [2:0] s);
        wr_en = 1'b1; wr_freq = f; wr_sel = s;
        step_check();
        wr_en = 1'b0;
    endtask

    task automatic stop();
        off_req = 1'b1;
        step_check();
        off_req = 1'b0;
    endtask

    initial begin
        logic [15:0] words [7];
        words = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h1234, 16'h4000, 16'h0100};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        @(negedge clk);
        check("R1 out", int'(clk_out), 0);
        check("R1 freq", int'(rd_freq), 0);
        check("R1 sel", int'(rd_sel), 0);
        check("R1 run", int'(rd_on), 0);

        // R3 R4 R5: sweep of every rate select against a word set
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 7; w++) begin
                out_tag = (words[w] == 16'h0) ? "R5 constant output" : "R3 R4 waveform";
                write_cfg(words[w], 3'(s));
                run(260 + (s * 40));
                out_tag = "R7 stop";
                stop();
                run(2);
            end
        end

        // R6: mid-run rewrite keeps phase and edge count
        out_tag = "R6 continuity";
        write_cfg(16'h1000, 3'd0);
        run(21);
        write_cfg(16'h3000, 3'd2);
        run(100);
        write_cfg(16'h0700, 3'd1);
        run(100);

        // R7: stop and write in the same cycle
        out_tag = "R7 stop wins";
        wr_en = 1'b1; wr_freq = 16'h2222; wr_sel = 3'd0; off_req = 1'b1;
        step_check();
        wr_en = 1'b0; off_req = 1'b0;
        check("R7 run after stop+write", int'(rd_on), 0);
        check("R7 output after stop+write", int'(clk_out), 0);
        run(5);

        // R8: gate low keeps accumulator running
        out_tag = "R8 pin gate";
        write_cfg(16'h0A00, 3'd1);
        run(50);
        pin_clk_mode = 1'b0;
        run(77);
        pin_clk_mode = 1'b1;
        run(120);
        stop();
        run(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule